// File: doc/BRIEF.md
# Boundary-Scan Test Port Controller

This block is the serial test port of a chip: a sixteen-state controller stepped by the test clock and the mode-select input, a four-bit instruction register with a fixed decode of five instructions, and the data registers that live inside the controller: a one-bit bypass stage and a 32-bit identification register. For the boundary-scan chain, which sits outside the block, it supplies the capture, shift and update strobes, the serial input, a mode bit for the cells and a global output-disable. The chain's serial output comes back to the block, which passes it on to the test data output.

There is no dedicated test reset pin. The controller reaches its reset state only through the power-on reset, through five test clocks with mode-select high, or when the port is disabled. With the enable low, the four test pins are free for ordinary use. The controller is then held in reset and the test data output stays undriven. The serial path is bit-serial at the test clock and has no flow control. Every bit offered on the data input is taken on a rising edge whenever the controller is in a shift state. There is no back-pressure and no valid flag: the shift states themselves mark which bits count.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: While `por_n` is low, the controller is in its reset state. In that state `tdo_oe`, `pins_hiz`, `bsc_mode` and all three chain strobes are low, and the active instruction is IDCODE, so the first data scan after reset returns the identification value.
- R2: Five consecutive rising edges of `tck` with `tms` high bring the controller to its reset state from any state. The active instruction becomes IDCODE at the moment that state is entered.
- R3: In the instruction-capture state the instruction shift register loads binary 0001. During an instruction shift it moves toward `tdo` least significant bit first, and it takes a new bit from `tdi` at the other end.
- R4: The instruction codes are EXTEST = 0000, SAMPLE/PRELOAD = 0001, IDCODE = 0010, HIGHZ = 0011 and BYPASS = 1111. Any other code acts as BYPASS. EXTEST and SAMPLE/PRELOAD both select the external chain. `bsc_mode` is high only for EXTEST.
- R5: Under IDCODE, the data-capture state loads the 32-bit identification value with its bit 0 forced to 1, whatever the parameter holds. The value is shifted out least significant bit first.
- R6: Under BYPASS, HIGHZ or an unused code, the data path is one stage deep. That stage loads 0 in data-capture, so a scan returns 0 followed by the input bits delayed by one clock.
- R7: `bsc_capture`, `bsc_shift` and `bsc_update` are each high only in data-capture, data-shift and data-update respectively, and only while the external chain is selected. `bsc_si` carries `tdi`. During the scan, `tdo` reproduces `bsc_so`.
- R8: `tdo` and `tdo_oe` change only on falling edges of `tck`. `tdo_oe` is high exactly in the falling-edge intervals that follow entry into the instruction-shift or data-shift state.
- R9: HIGHZ drives `pins_hiz` high from instruction update until another instruction is loaded or the reset state is entered. While it is active, the chain strobes stay low.
- R10: When `tap_en` goes low, `tdo_oe` drops at once and the controller is held in reset. After `tap_en` returns high, the active instruction is IDCODE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tap_en | input | 1 | Port enable; low hands the pins back and holds reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` |
| bsc_capture | output | 1 | Chain capture strobe |
| bsc_shift | output | 1 | Chain shift strobe |
| bsc_update | output | 1 | Chain update strobe |
| bsc_mode | output | 1 | Cells drive pins from their update stage (EXTEST) |
| bsc_si | output | 1 | Serial input to the chain |
| bsc_so | input | 1 | Serial output of the chain |
| pins_hiz | output | 1 | Global output-disable for all pins |

## Verification
The most delicate cycle is the one that leaves a shift state. On that rising edge the last data bit moves in from `tdi` while `tms` high moves the controller to exit, and the same edge can also be the first of a five-edge reset. The bench provokes this by cutting a bypass scan short with a run of five high `tms` clocks while HIGHZ is active. The scoreboard expects exactly the bits driven before the exit and nothing after. It then checks that `pins_hiz` has dropped once the reset state is reached and that the next data scan returns the identification value.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET   = 4'hF,
    ST_IDLE    = 4'hC,
    ST_SEL_DR  = 4'h7,
    ST_CAP_DR  = 4'h6,
    ST_SH_DR   = 4'h2,
    ST_EX1_DR  = 4'h1,
    ST_PAU_DR  = 4'h3,
    ST_EX2_DR  = 4'h0,
    ST_UPD_DR  = 4'h5,
    ST_SEL_IR  = 4'h4,
    ST_CAP_IR  = 4'hE,
    ST_SH_IR   = 4'hA,
    ST_EX1_IR  = 4'h9,
    ST_PAU_IR  = 4'hB,
    ST_EX2_IR  = 4'h8,
    ST_UPD_IR  = 4'hD
  } tap_state_e;

  localparam int IR_W = 4;

  localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0001;
  localparam logic [IR_W-1:0] OP_IDCODE  = 4'b0010;
  localparam logic [IR_W-1:0] OP_HIGHZ   = 4'b0011;
  localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  typedef enum logic [1:0] {
    DR_BYP = 2'd0,
    DR_ID  = 2'd1,
    DR_BSC = 2'd2
  } dr_sel_e;

  typedef struct packed {
    dr_sel_e sel;
    logic    ext_mode;
    logic    hiz;
  } ir_dec_t;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
#(
  parameter int RESET_RUN = 5
) (
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  localparam int CNT_W = $clog2(RESET_RUN + 1);

  tap_state_e nxt;

  always_comb begin
    case (state)
      ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_RESET;
    else        state <= nxt;
  end

  // Run length of high tms, used by the checker below
  logic [CNT_W-1:0] ones_cnt;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                                   ones_cnt <= '0;
    else if (!tms)                                ones_cnt <= '0;
    else if (ones_cnt != CNT_W'(RESET_RUN))       ones_cnt <= ones_cnt + 1'b1;
  end

  a_r2_tms_reset: assert property (@(posedge tck) disable iff (!rst_n)
    (ones_cnt == CNT_W'(RESET_RUN)) |-> (state == ST_RESET));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  tap_state_e state,
  input  logic       tdi,
  output logic       ir_so,
  output ir_dec_t    dec
);

  logic [IR_W-1:0] ir_sr;
  logic [IR_W-1:0] ir_q;
  logic [IR_W-1:0] ir_eff;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir_sr <= IR_CAPTURE;
      ir_q  <= OP_IDCODE;
    end else begin
      case (state)
        ST_CAP_IR: ir_sr <= IR_CAPTURE;
        ST_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        ST_UPD_IR: ir_q  <= ir_sr;
        ST_RESET:  ir_q  <= OP_IDCODE;
        default:   ;
      endcase
    end
  end

  // The reset state forces IDCODE without waiting for a clock
  assign ir_eff = (state == ST_RESET) ? OP_IDCODE : ir_q;
  assign ir_so  = ir_sr[0];

  always_comb begin
    dec.ext_mode = 1'b0;
    dec.hiz      = 1'b0;
    case (ir_eff)
      OP_EXTEST: begin dec.sel = DR_BSC; dec.ext_mode = 1'b1; end
      OP_SAMPLE: dec.sel = DR_BSC;
      OP_IDCODE: dec.sel = DR_ID;
      OP_HIGHZ:  begin dec.sel = DR_BYP; dec.hiz = 1'b1; end
      default:   dec.sel = DR_BYP;
    endcase
  end

  a_r3_capture_value: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_IR) |=> (ir_sr == IR_CAPTURE));

  a_r1_reset_idcode: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_RESET) |-> (dec.sel == DR_ID && !dec.hiz && !dec.ext_mode));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = '1
) (
  input  logic       tck,
  input  logic       rst_n,
  input  tap_state_e state,
  input  dr_sel_e    sel,
  input  logic       tdi,
  input  logic       bsc_so,
  output logic       dr_so
);

  localparam logic [ID_W-1:0] ID_CAPT = ID_VALUE | ID_W'(1);

  logic            byp_q;
  logic [ID_W-1:0] id_sr;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
      id_sr <= ID_CAPT;
    end else begin
      if (sel == DR_BYP) begin
        if (state == ST_CAP_DR)     byp_q <= 1'b0;
        else if (state == ST_SH_DR) byp_q <= tdi;
      end
      if (sel == DR_ID) begin
        if (state == ST_CAP_DR)     id_sr <= ID_CAPT;
        else if (state == ST_SH_DR) id_sr <= {tdi, id_sr[ID_W-1:1]};
      end
    end
  end

  always_comb begin
    case (sel)
      DR_ID:   dr_so = id_sr[0];
      DR_BSC:  dr_so = bsc_so;
      default: dr_so = byp_q;
    endcase
  end

  a_r6_bypass_zero: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_DR && sel == DR_BYP) |=> (byp_q == 1'b0));

  a_r5_id_lsb_one: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_DR && sel == DR_ID) |=> (id_sr[0] == 1'b1));

endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
  import tap_pkg::*;
#(
  parameter int              ID_W      = 32,
  parameter logic [ID_W-1:0] ID_VALUE  = 32'h1B3C_5A01,
  parameter int              RESET_RUN = 5
) (
  input  logic tck,
  input  logic por_n,
  input  logic tap_en,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_oe,
  output logic bsc_capture,
  output logic bsc_shift,
  output logic bsc_update,
  output logic bsc_mode,
  output logic bsc_si,
  input  logic bsc_so,
  output logic pins_hiz
);

  logic       rst_n;
  tap_state_e state;
  ir_dec_t    dec;
  logic       ir_so;
  logic       dr_so;
  logic       chain_sel;
  logic       tdo_q;
  logic       oe_q;

  assign rst_n = por_n & tap_en;

  tap_fsm #(.RESET_RUN(RESET_RUN)) u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state)
  );

  tap_ir u_ir (
    .tck   (tck),
    .rst_n (rst_n),
    .state (state),
    .tdi   (tdi),
    .ir_so (ir_so),
    .dec   (dec)
  );

  tap_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
    .tck    (tck),
    .rst_n  (rst_n),
    .state  (state),
    .sel    (dec.sel),
    .tdi    (tdi),
    .bsc_so (bsc_so),
    .dr_so  (dr_so)
  );

  assign chain_sel   = (dec.sel == DR_BSC);
  assign bsc_capture = chain_sel && (state == ST_CAP_DR);
  assign bsc_shift   = chain_sel && (state == ST_SH_DR);
  assign bsc_update  = chain_sel && (state == ST_UPD_DR);
  assign bsc_mode    = dec.ext_mode;
  assign pins_hiz    = dec.hiz;
  assign bsc_si      = tdi;

  // Output stage moves on the falling edge, half a clock after the shift
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q  <= (state == ST_SH_DR) || (state == ST_SH_IR);
      tdo_q <= (state == ST_SH_IR) ? ir_so : dr_so;
    end
  end

  assign tdo    = tdo_q;
  assign tdo_oe = oe_q;

  a_r7_strobe_onehot: assert property (@(posedge tck) disable iff (!rst_n)
    $onehot0({bsc_capture, bsc_shift, bsc_update}));

  a_r8_oe_in_shift: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe |-> (state == ST_SH_DR || state == ST_SH_IR));

  a_r9_hiz_no_chain: assert property (@(posedge tck) disable iff (!rst_n)
    pins_hiz |-> !(bsc_capture || bsc_shift || bsc_update || bsc_mode));

endmodule

// File: tb/jtag_tap_ctrl_bench.sv
module jtag_tap_ctrl_bench;

  localparam int          TCK_PERIOD = 20;
  localparam logic [31:0] ID_PARAM   = 32'h2C5A_7E12;
  localparam logic [31:0] ID_EXP     = 32'h2C5A_7E13;   // R5: bit 0 forced to 1

  logic tck = 1'b0;
  logic por_n = 1'b0;
  logic tap_en = 1'b1;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic tdo, tdo_oe, bsc_capture, bsc_shift, bsc_update, bsc_mode, bsc_si, bsc_so, pins_hiz;

  int errors = 0;
  int checks = 0;
  bit exp_q[$];
  logic upd_seen;

  jtag_tap_ctrl #(.ID_W(32), .ID_VALUE(ID_PARAM), .RESET_RUN(5)) u_jtag_tap_ctrl (
    .tck(tck), .por_n(por_n), .tap_en(tap_en), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdo_oe(tdo_oe), .bsc_capture(bsc_capture), .bsc_shift(bsc_shift),
    .bsc_update(bsc_update), .bsc_mode(bsc_mode), .bsc_si(bsc_si), .bsc_so(bsc_so),
    .pins_hiz(pins_hiz)
  );

  always #(TCK_PERIOD/2) tck = ~tck;

  // External chain model: strobes latched at the falling edge, applied at the rising edge
  logic [3:0] chain = 4'h0;
  logic cap_l = 1'b0, sh_l = 1'b0;
  always @(negedge tck) begin
    cap_l <= bsc_capture;
    sh_l  <= bsc_shift;
  end
  always @(posedge tck) begin
    if (cap_l)     chain <= 4'hA;
    else if (sh_l) chain <= {bsc_si, chain[3:1]};
  end
  assign bsc_so = chain[0];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every driven tdo bit is compared with the queue head (R8)
  always @(negedge tck) begin
    #2;
    if (tdo_oe === 1'b1) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8 tdo driven with no bit expected: actual=%0b expected=none", tdo);
      end else begin
        bit e;
        e = exp_q.pop_front();
        if (tdo !== e) begin
          errors++;
          $display("FAIL R8 serial bit: actual=%0b expected=%0b", tdo, e);
        end
      end
    end
  end

  task automatic step(input bit m, input bit d);
    @(negedge tck); #1;
    tms = m; tdi = d;
    @(posedge tck); #1;
  endtask

  task automatic push_bits(input logic [63:0] v, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(v[i]);
  endtask

  task automatic push_bypass(input logic [63:0] v, input int n);
    exp_q.push_back(1'b0);
    for (int i = 0; i < n - 1; i++) exp_q.push_back(v[i]);
  endtask

  task automatic load_ir(input logic [3:0] code);
    push_bits(64'b0001, 4);                 // R3: captured 0001, LSB first
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) step(i == 3, code[i]);
    step(1, 0);
    step(0, 0);
    chk("R3 instruction bits consumed", exp_q.size(), 0);
  endtask

  task automatic scan_dr(input logic [63:0] d, input int n);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) step(i == n - 1, d[i]);
    step(1, 0);
    upd_seen = bsc_update;
    step(0, 0);
    chk("R8 data bits consumed", exp_q.size(), 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(TCK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    // R1: power-on reset state
    repeat (3) @(posedge tck);
    #1;
    chk("R1 tdo_oe in reset", tdo_oe, 0);
    chk("R1 pins_hiz in reset", pins_hiz, 0);
    chk("R1 bsc_mode in reset", bsc_mode, 0);
    chk("R1 strobes in reset", {bsc_capture, bsc_shift, bsc_update}, 0);
    @(negedge tck); #1 por_n = 1'b1;

    // R1, R5: IDCODE active after power-up
    step(0, 0);
    push_bits({32'h0, ID_EXP}, 32);
    scan_dr(64'h0123_4567_89AB_CDEF, 32);

    // R6: bypass one-bit delay
    load_ir(4'b1111);
    push_bypass(64'hB2, 8);
    scan_dr(64'hB2, 8);

    // R4: unused code acts as bypass
    load_ir(4'b0101);
    chk("R4 unused code mode", {pins_hiz, bsc_mode}, 0);
    push_bypass(64'h2D, 6);
    scan_dr(64'h2D, 6);

    // R4, R7: EXTEST through the external chain
    load_ir(4'b0000);
    chk("R4 EXTEST mode", bsc_mode, 1);
    chk("R4 EXTEST no hiz", pins_hiz, 0);
    push_bits(64'h6A, 8);                    // 4'hA captured then d[3:0]=6
    scan_dr(64'hC6, 8);
    chk("R7 update strobe", upd_seen, 1);
    chk("R7 chain contents", chain, 4'hC);

    // R4: SAMPLE/PRELOAD selects chain, mode low
    load_ir(4'b0001);
    chk("R4 SAMPLE mode", bsc_mode, 0);
    push_bits(64'hA, 4);
    scan_dr(64'h5, 4);
    chk("R7 chain after sample", chain, 4'h5);

    // R4, R5: explicit IDCODE
    load_ir(4'b0010);
    push_bits({32'h0, ID_EXP}, 32);
    scan_dr(64'hFFFF_FFFF, 32);

    // R9: HIGHZ
    load_ir(4'b0011);
    chk("R9 pins_hiz after update", pins_hiz, 1);
    push_bypass(64'h13, 5);
    scan_dr(64'h13, 5);
    chk("R9 no chain update", upd_seen, 0);
    chk("R9 chain untouched", chain, 4'h5);

    // R2: five high tms clocks from inside a data shift, while HIGHZ is active
    step(1, 0); step(0, 0); step(0, 0);
    exp_q.push_back(1'b0); exp_q.push_back(1'b1); exp_q.push_back(1'b0);
    step(0, 1); step(0, 0);
    repeat (5) step(1, 0);
    chk("R2 hiz dropped at reset", pins_hiz, 0);
    chk("R2 bits consumed", exp_q.size(), 0);
    step(0, 0);
    push_bits({32'h0, ID_EXP}, 32);
    scan_dr(64'h0, 32);

    // R10: disable during a shift
    load_ir(4'b1111);
    step(1, 0); step(0, 0); step(0, 0);
    exp_q.push_back(1'b0);
    step(0, 1);
    chk("R10 oe before disable", tdo_oe, 1);
    tap_en = 1'b0;
    #1;
    chk("R10 oe drops at disable", tdo_oe, 0);
    repeat (3) step(0, 1);
    chk("R10 oe stays low", tdo_oe, 0);
    chk("R10 strobes low", {bsc_capture, bsc_shift, bsc_update, pins_hiz}, 0);
    tap_en = 1'b1;
    step(1, 0);
    step(0, 0);
    push_bits({32'h0, ID_EXP}, 32);
    scan_dr(64'h5555_5555, 32);
    chk("R10 idle after scan", tdo_oe, 0);

    finish_run();
  end

endmodule